// File: doc/BRIEF.md
# Aligned Vector Store Unit

This unit executes one indexed store of a 128-bit vector register. It takes a 32-bit instruction word, checks it against two encodings (a compact form that can name 32 vector registers and a wide form that can name 128), fetches two 64-bit integer registers and one vector register through a request/response read port, and then issues a single 16-byte write to memory.

The effective address is the sum of a base and an index register. The sum is forced down to a 16-byte boundary and never raises a fault. A base register number of zero means the constant zero. Bytes leave the unit with the most significant vector byte at the lowest address. When address reservations are enabled and one is live, an invalidate for the line is pulsed before the write is offered. The unit reports the following program counter when the write completes. While a store is in flight, the unit is busy and takes no new instruction.

Top module: `vec_store_unit`

## Requirements
- R1: Bit 0 is the most significant bit of the instruction word (`ins_word[31]`). The compact form is recognised when bits 0–5 equal 31 and bits 21–30 equal 231, for example 0x7C0001CE. Its vector register is bits 6–10, its base register is bits 11–15 and its index register is bits 16–20. A recognised word presented with `ins_valid` while `ins_ready` is high raises `ins_accept` in the same cycle.
- R2: The wide form is recognised when bits 0–5 equal 4, bits 21–27 equal 0x1C and bits 30–31 equal 3, for example 0x100001C3. Its base and index fields sit where they do in the compact form. Its 7-bit vector register number is bits 28–29 (upper two bits) joined to bits 6–10 (lower five bits).
- R3: A word that matches neither form leaves `ins_accept` low. It causes no register read, no invalidate and no memory write.
- R4: A base field of 0 makes the base the constant zero, whatever value the read port returns for register 0.
- R5: `mem_addr` equals the low 32 bits of the base plus the index (modulo 2^64), with bits 3:0 forced to zero. A misaligned sum is still stored.
- R6: Bits [8k+7:8k] of `mem_data` are the byte at address `mem_addr`+k. The byte at `mem_addr` is bits 127:120 of the vector register, and the byte at `mem_addr`+15 is bits 7:0.
- R7: `mem_valid` rises two cycles after the read response is taken and stays high until `mem_ready`, with `mem_addr` and `mem_data` held stable. Each accepted instruction produces exactly one write.
- R8: If `resv_enable` and `resv_active` are both high in the cycle after the read response, `inval_valid` pulses for one cycle with `inval_addr` equal to the store address. This pulse comes in the cycle before `mem_valid` rises. Otherwise `inval_valid` stays low.
- R9: From the accepting edge until the write handshake completes, `ins_ready` and `ins_accept` stay low.
- R10: In the cycle of the write handshake, `pc_step` is high and `next_pc` equals the accepted `ins_pc` plus 4. No register is written.
- R11: After reset, `ins_ready` is high and `rd_req`, `inval_valid`, `mem_valid` and `pc_step` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ins_valid | input | 1 | Instruction word present |
| ins_word | input | 32 | Instruction word |
| ins_pc | input | 32 | Address of the instruction |
| ins_ready | output | 1 | Unit idle, able to take an instruction |
| ins_accept | output | 1 | Instruction recognised and taken this cycle |
| rd_req | output | 1 | Register read request, held until response |
| rd_ra_idx | output | 5 | Base register number |
| rd_rb_idx | output | 5 | Index register number |
| rd_vr_idx | output | 7 | Vector register number |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_ra_data | input | 64 | Base register contents |
| rd_rb_data | input | 64 | Index register contents |
| rd_vr_data | input | 128 | Vector register contents |
| resv_enable | input | 1 | Reservation mechanism enabled |
| resv_active | input | 1 | At least one reservation is live |
| inval_valid | output | 1 | Reservation invalidate pulse |
| inval_addr | output | 32 | Line address to invalidate |
| mem_valid | output | 1 | Write request |
| mem_ready | input | 1 | Memory takes the write |
| mem_addr | output | 32 | 16-byte-aligned write address |
| mem_data | output | 128 | Write data, byte k at address+k |
| pc_step | output | 1 | Instruction completes this cycle |
| next_pc | output | 32 | Program counter after the store |

## Verification
The bench targets five kinds of error:

- **Misread wide form.** The vector number is split across two fields. A unit that dropped or swapped the two upper bits would fetch the wrong register, so the test uses an index with both upper bits significant.
- **Register zero as base.** The read port returns a non-zero value for register 0. A unit that used it would write to a shifted address.
- **Address arithmetic.** Sums that are misaligned, and sums that carry past bit 63 and past bit 31, expose a unit that traps, leaves low bits set or truncates in the wrong place.
- **Byte reversal.** An unreversed or half-reversed data bus shows up immediately with the chosen vector patterns.
- **Handshake and invalidate.** A stalled `mem_ready`, with another instruction offered during the stall, catches a unit that moves its data or accepts early. The mixed reservation inputs catch an invalidate that is gated on only one of its two conditions.

// File: rtl/vsu_pkg.sv
package vsu_pkg;
   localparam int GPR_IDX_W = 5;
   localparam int VR_IDX_W  = 7;

   localparam logic [5:0] OP_STD = 6'd31;
   localparam logic [9:0] XO_STD = 10'd231;
   localparam logic [5:0] OP_WIDE = 6'd4;
   localparam logic [6:0] XO_WIDE = 7'h1C;
   localparam logic [1:0] TAIL_WIDE = 2'b11;

   localparam int PC_STEP = 4;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_READ = 2'd1,
      ST_INV  = 2'd2,
      ST_WRITE = 2'd3
   } vsu_state_t;

   typedef struct packed {
      logic                 legal;
      logic                 wide;
      logic [GPR_IDX_W-1:0] ra;
      logic [GPR_IDX_W-1:0] rb;
      logic [VR_IDX_W-1:0]  vs;
   } vsu_dec_t;
endpackage

// File: rtl/vsu_decode.sv
module vsu_decode
   import vsu_pkg::*;
#(
   parameter bit ENABLE_WIDE = 1'b1
) (
   input  logic [31:0] word_i,
   output vsu_dec_t    dec_o
);
   logic [5:0] opcd;
   logic       std_hit;
   logic       wide_hit;
   logic [4:0] vs_lo;

   assign opcd    = word_i[31:26];
   assign vs_lo   = word_i[25:21];
   assign std_hit = (opcd == OP_STD) && (word_i[10:1] == XO_STD);

   generate
      if (ENABLE_WIDE) begin : g_wide
         assign wide_hit = (opcd == OP_WIDE) && (word_i[10:4] == XO_WIDE)
                           && (word_i[1:0] == TAIL_WIDE);
      end else begin : g_narrow
         logic unused_tail;
         assign unused_tail = ^{word_i[3:2], word_i[0]};
         assign wide_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      dec_o.legal = std_hit | wide_hit;
      dec_o.wide  = wide_hit;
      dec_o.ra    = word_i[20:16];
      dec_o.rb    = word_i[15:11];
      dec_o.vs    = wide_hit ? {word_i[3:2], vs_lo} : {2'b00, vs_lo};
   end
endmodule

// File: rtl/vsu_agen.sv
module vsu_agen #(
   parameter int GPR_W     = 64,
   parameter int ADDR_W    = 32,
   parameter int ALIGN_LG2 = 4
) (
   input  logic              base_zero_i,
   input  logic [GPR_W-1:0]  base_i,
   input  logic [GPR_W-1:0]  index_i,
   output logic [ADDR_W-1:0] ea_o
);
   logic [GPR_W-1:0] base_eff;
   logic [GPR_W-1:0] sum;
   logic [GPR_W-1:0] sum_al;

   assign base_eff = base_zero_i ? '0 : base_i;
   assign sum      = base_eff + index_i;
   assign sum_al   = {sum[GPR_W-1:ALIGN_LG2], {ALIGN_LG2{1'b0}}};
   assign ea_o     = sum_al[ADDR_W-1:0];

   generate
      if (GPR_W > ADDR_W) begin : g_drop
         logic unused_hi;
         assign unused_hi = ^sum_al[GPR_W-1:ADDR_W];
      end
   endgenerate
endmodule

// File: rtl/vsu_lane_swap.sv
module vsu_lane_swap #(
   parameter int VR_W = 128
) (
   input  logic [VR_W-1:0] reg_i,
   output logic [VR_W-1:0] bus_o
);
   localparam int NBYTES = VR_W / 8;

   generate
      for (genvar k = 0; k < NBYTES; k++) begin : g_byte
         assign bus_o[8*k +: 8] = reg_i[VR_W-8-8*k +: 8];
      end
   endgenerate
endmodule

// File: rtl/vec_store_unit.sv
module vec_store_unit
   import vsu_pkg::*;
#(
   parameter int GPR_W       = 64,
   parameter int VR_W        = 128,
   parameter int ADDR_W      = 32,
   parameter bit ENABLE_WIDE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ins_valid,
   input  logic [31:0]          ins_word,
   input  logic [ADDR_W-1:0]    ins_pc,
   output logic                 ins_ready,
   output logic                 ins_accept,
   output logic                 rd_req,
   output logic [GPR_IDX_W-1:0] rd_ra_idx,
   output logic [GPR_IDX_W-1:0] rd_rb_idx,
   output logic [VR_IDX_W-1:0]  rd_vr_idx,
   input  logic                 rd_rsp_valid,
   input  logic [GPR_W-1:0]     rd_ra_data,
   input  logic [GPR_W-1:0]     rd_rb_data,
   input  logic [VR_W-1:0]      rd_vr_data,
   input  logic                 resv_enable,
   input  logic                 resv_active,
   output logic                 inval_valid,
   output logic [ADDR_W-1:0]    inval_addr,
   output logic                 mem_valid,
   input  logic                 mem_ready,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic [VR_W-1:0]      mem_data,
   output logic                 pc_step,
   output logic [ADDR_W-1:0]    next_pc
);
   localparam int ALIGN_LG2 = $clog2(VR_W / 8);

   generate
      if (VR_W % 8 != 0) begin : g_bad_vr
         $error("VR_W must be a whole number of bytes");
      end
      if (ADDR_W > GPR_W) begin : g_bad_addr
         $error("ADDR_W must not exceed GPR_W");
      end
      if ((8 << ALIGN_LG2) != VR_W) begin : g_bad_pow
         $error("VR_W must be a power-of-two number of bytes");
      end
   endgenerate

   vsu_state_t state_q, state_d;
   vsu_dec_t   dec;
   logic [GPR_IDX_W-1:0] ra_q, rb_q;
   logic [VR_IDX_W-1:0]  vs_q;
   logic [ADDR_W-1:0]    pc_q;
   logic [ADDR_W-1:0]    ea_q;
   logic [VR_W-1:0]      data_q;
   logic [ADDR_W-1:0]    ea_w;
   logic [VR_W-1:0]      swap_w;
   logic                 wr_done;

   vsu_decode #(.ENABLE_WIDE(ENABLE_WIDE)) u_dec (
      .word_i (ins_word),
      .dec_o  (dec)
   );

   vsu_agen #(.GPR_W(GPR_W), .ADDR_W(ADDR_W), .ALIGN_LG2(ALIGN_LG2)) u_agen (
      .base_zero_i (ra_q == '0),
      .base_i      (rd_ra_data),
      .index_i     (rd_rb_data),
      .ea_o        (ea_w)
   );

   vsu_lane_swap #(.VR_W(VR_W)) u_swap (
      .reg_i (rd_vr_data),
      .bus_o (swap_w)
   );

   assign ins_ready  = (state_q == ST_IDLE);
   assign ins_accept = ins_valid & ins_ready & dec.legal;
   assign rd_req     = (state_q == ST_READ);
   assign rd_ra_idx  = ra_q;
   assign rd_rb_idx  = rb_q;
   assign rd_vr_idx  = vs_q;
   assign inval_valid = (state_q == ST_INV) & resv_enable & resv_active;
   assign inval_addr = ea_q;
   assign mem_valid  = (state_q == ST_WRITE);
   assign mem_addr   = ea_q;
   assign mem_data   = data_q;
   assign wr_done    = mem_valid & mem_ready;
   assign pc_step    = wr_done;
   assign next_pc    = pc_q + ADDR_W'(PC_STEP);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (ins_accept)   state_d = ST_READ;
         ST_READ:  if (rd_rsp_valid) state_d = ST_INV;
         ST_INV:                     state_d = ST_WRITE;
         ST_WRITE: if (mem_ready)    state_d = ST_IDLE;
         default:                    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ra_q    <= '0;
         rb_q    <= '0;
         vs_q    <= '0;
         pc_q    <= '0;
         ea_q    <= '0;
         data_q  <= '0;
      end else begin
         state_q <= state_d;
         if (ins_accept) begin
            ra_q <= dec.ra;
            rb_q <= dec.rb;
            vs_q <= dec.vs;
            pc_q <= ins_pc;
         end
         if (rd_req && rd_rsp_valid) begin
            ea_q   <= ea_w;
            data_q <= swap_w;
         end
      end
   end
endmodule

// File: rtl/vsu_chk.sv
module vsu_chk #(
   parameter int VR_W   = 128,
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ins_valid,
   input logic              ins_accept,
   input logic              ins_ready,
   input logic              rd_req,
   input logic              rd_rsp_valid,
   input logic              inval_valid,
   input logic [ADDR_W-1:0] inval_addr,
   input logic              mem_valid,
   input logic              mem_ready,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [VR_W-1:0]   mem_data,
   input logic              pc_step
);
   AST_ACCEPT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      ins_accept |-> ins_valid);                                            // R3
   AST_ACCEPT_STARTS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      ins_accept |=> rd_req && !ins_ready);                                 // R9
   AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req || mem_valid || inval_valid) |-> !ins_accept);                // R9
   AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> mem_valid && $stable(mem_addr) && $stable(mem_data)); // R7
   AST_WR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> (mem_addr[3:0] == 4'h0));                               // R5
   AST_INV_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
      inval_valid |=> mem_valid && (mem_addr == $past(inval_addr)));        // R8
   AST_RSP_TO_WR: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_rsp_valid) |=> !mem_valid);                             // R7
   AST_STEP_ON_WR: assert property (@(posedge clk) disable iff (!rst_n)
      pc_step |-> (mem_valid && mem_ready));                                // R10
endmodule

bind vec_store_unit vsu_chk #(.VR_W(VR_W), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/vec_store_unit_tb_top.sv
`timescale 1ns/1ps
module vec_store_unit_tb_top;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ins_valid = 1'b0;
   logic [31:0]  ins_word = '0;
   logic [31:0]  ins_pc = '0;
   logic         ins_ready, ins_accept, rd_req;
   logic [4:0]   rd_ra_idx, rd_rb_idx;
   logic [6:0]   rd_vr_idx;
   logic         rd_rsp_valid = 1'b0;
   logic [63:0]  rd_ra_data = '0, rd_rb_data = '0;
   logic [127:0] rd_vr_data = '0;
   logic         resv_enable = 1'b0, resv_active = 1'b0;
   logic         inval_valid;
   logic [31:0]  inval_addr;
   logic         mem_valid;
   logic         mem_ready = 1'b0;
   logic [31:0]  mem_addr;
   logic [127:0] mem_data;
   logic         pc_step;
   logic [31:0]  next_pc;

   int total = 0;
   int bad = 0;
   logic [63:0]  gpr [32];
   logic [127:0] vrf [128];
   logic [31:0]  cur_pc = 32'h0000_1000;

   always #10 clk = ~clk;

   vec_store_unit dut_i (.*);

   task automatic chk(input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] w_std(input logic [4:0] vs, ra, rb);
      return {6'd31, vs, ra, rb, 10'd231, 1'b0};
   endfunction

   function automatic logic [31:0] w_wide(input logic [6:0] vs, input logic [4:0] ra, rb);
      return {6'd4, vs[4:0], ra, rb, 7'h1C, vs[6:5], 2'b11};
   endfunction

   task automatic run_store(input string req, input logic [31:0] w,
                            input logic [4:0] ra, input logic [4:0] rb, input logic [6:0] vs,
                            input logic en, input logic any, input int dly);
      logic [63:0]  base, sum;
      logic [31:0]  exp_ea, pc_here;
      logic [127:0] exp_d;
      base = (ra == 5'd0) ? 64'd0 : gpr[ra];
      sum = base + gpr[rb];
      exp_ea = {sum[31:4], 4'h0};
      for (int k = 0; k < 16; k++) exp_d[8*k +: 8] = vrf[vs][127-8*k -: 8];
      pc_here = cur_pc;
      cur_pc = cur_pc + 32'd4;
      resv_enable = en;
      resv_active = any;
      @(negedge clk);
      ins_valid = 1'b1; ins_word = w; ins_pc = pc_here;
      #1 chk(req, "accept", 128'(ins_accept), 128'd1);
      @(negedge clk);
      ins_valid = 1'b0;
      chk(req, "rd_req", 128'(rd_req), 128'd1);
      chk(req, "vr index", 128'(rd_vr_idx), 128'(vs));
      chk(req, "ra/rb index", 128'({rd_ra_idx, rd_rb_idx}), 128'({ra, rb}));
      rd_ra_data = gpr[rd_ra_idx]; rd_rb_data = gpr[rd_rb_idx];
      rd_vr_data = vrf[rd_vr_idx]; rd_rsp_valid = 1'b1;
      @(negedge clk);
      rd_rsp_valid = 1'b0;
      chk("R8", "inval", 128'(inval_valid), 128'(en & any));
      if (en & any) chk("R8", "inval addr", 128'(inval_addr), 128'(exp_ea));
      chk("R7", "no early write", 128'(mem_valid), 128'd0);
      @(negedge clk);
      chk("R7", "mem_valid", 128'(mem_valid), 128'd1);
      chk(req, "addr", 128'(mem_addr), 128'(exp_ea));
      chk("R6", "data", mem_data, exp_d);
      for (int i = 0; i < dly; i++) begin
         ins_valid = 1'b1; ins_word = w_std(5'd1, 5'd2, 5'd3);
         #1 chk("R9", "busy accept", 128'({ins_accept, ins_ready}), 128'd0);
         chk("R10", "no early step", 128'(pc_step), 128'd0);
         @(negedge clk);
         chk("R7", "held", 128'({mem_valid, mem_addr}), 128'({1'b1, exp_ea}));
         chk("R7", "held data", mem_data, exp_d);
      end
      ins_valid = 1'b0;
      mem_ready = 1'b1;
      #1 chk("R10", "pc_step", 128'(pc_step), 128'd1);
      chk("R10", "next_pc", 128'(next_pc), 128'(pc_here + 32'd4));
      @(negedge clk);
      mem_ready = 1'b0;
      chk("R7", "single write", 128'({mem_valid, ins_ready}), 128'b01);
   endtask

   task automatic t_reset();
      chk("R11", "idle outputs", 128'({ins_ready, rd_req, inval_valid, mem_valid, pc_step}),
          128'b10000);
   endtask

   task automatic t_compact();
      run_store("R1", w_std(5'd9, 5'd3, 5'd7), 5'd3, 5'd7, 7'd9, 1'b1, 1'b1, 0);
   endtask

   task automatic t_wide();
      run_store("R2", w_wide(7'h5A, 5'd4, 5'd5), 5'd4, 5'd5, 7'h5A, 1'b0, 1'b0, 0);
      run_store("R2", w_wide(7'h7F, 5'd6, 5'd3), 5'd6, 5'd3, 7'h7F, 1'b0, 1'b1, 1);
   endtask

   task automatic t_zero_base();
      run_store("R4", w_std(5'd2, 5'd0, 5'd8), 5'd0, 5'd8, 7'd2, 1'b1, 1'b0, 0);
   endtask

   task automatic t_wrap();
      run_store("R5", w_std(5'd17, 5'd10, 5'd11), 5'd10, 5'd11, 7'd17, 1'b0, 1'b0, 0);
   endtask

   task automatic t_stall();
      run_store("R7", w_std(5'd30, 5'd12, 5'd13), 5'd12, 5'd13, 7'd30, 1'b1, 1'b1, 3);
   endtask

   task automatic t_illegal();
      logic [31:0] words [4];
      words[0] = {6'd31, 5'd1, 5'd2, 5'd3, 10'd232, 1'b0};
      words[1] = {6'd4, 5'd1, 5'd2, 5'd3, 7'h1C, 2'b00, 2'b00};
      words[2] = {6'd30, 5'd1, 5'd2, 5'd3, 10'd231, 1'b0};
      words[3] = {6'd4, 5'd1, 5'd2, 5'd3, 7'h1D, 2'b00, 2'b11};
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         ins_valid = 1'b1; ins_word = words[i];
         #1 chk("R3", "reject", 128'(ins_accept), 128'd0);
         @(negedge clk);
         ins_valid = 1'b0;
         for (int c = 0; c < 3; c++) begin
            chk("R3", "quiet", 128'({rd_req, inval_valid, mem_valid, ins_ready}), 128'b0001);
            @(negedge clk);
         end
      end
   endtask

   initial begin
      for (int i = 0; i < 32; i++) gpr[i] = {32'hA5A5_0000 + 32'(i), 32'h0100_0000 + 32'(i * 37)};
      gpr[0]  = 64'hDEAD_BEEF_0000_0F00;
      gpr[3]  = 64'h0000_0000_0000_2003;
      gpr[7]  = 64'h0000_0000_0000_0049;
      gpr[8]  = 64'h0000_0000_0000_5557;
      gpr[10] = 64'hFFFF_FFFF_FFFF_FFF8;
      gpr[11] = 64'h1234_0001_8000_0015;
      gpr[12] = 64'h0000_0000_FFFF_FFF0;
      gpr[13] = 64'h0000_0000_0000_002F;
      for (int i = 0; i < 128; i++)
         for (int b = 0; b < 16; b++) vrf[i][8*b +: 8] = 8'(i * 16 + b + 1);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_compact();
      t_wide();
      t_zero_base();
      t_wrap();
      t_stall();
      t_illegal();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule